// File: doc/BRIEF.md
# Overloaded Code-Division Shared Bus Core

This block is the shared transmit fabric of a code-division on-chip bus that carries half again as many single-bit senders as the spreading length allows. A frame spans `N` chip cycles. Each of the `N` code-sharing users spreads its bit with its own Walsh sequence. Each of the `N/2` pair-parity users places one pulse, at the first chip of its own chip pair, and only when its bit is one. On every chip cycle the block adds up all `1.5N` chip values. It broadcasts the registered count to every receiver that is attached downstream.

A frame begins with a one-cycle `start_i` pulse while the core reports `idle_o`. At that edge the core captures every user's data bit. A single shared chip counter then steps through the chip positions, and this counter indexes the code of every user. The chip values are registered before the adder and the sum is registered after it, so each sum appears two cycles after its chip index. `sum_vld_o` and `sum_first_o` mark the sums so that receivers can align their frame start to this delay. `valid_o` rises together with the last sum of the frame and stays high until `ack_i` is seen. The core then returns to idle.

Top module: `oci_bus_core`

## Requirements
- R1: After reset, and until the first start, `idle_o`=1, `valid_o`=0, `sum_vld_o`=0, `sum_first_o`=0 and `sum_o`=0. An asynchronous reset in the middle of a frame puts the core back into this state.
- R2: A `start_i` high at a clock edge while `idle_o`=1 captures `orth_bits_i` and `pd_bits_i` and clears `idle_o`. `chip_idx_o` is 0 right after that edge and then counts up by one per cycle to `N-1`.
- R3: The chip of code-sharing user k at chip index c is `orth_bits[k] XOR parity(k AND c)`, where c runs 0..N-1 and the AND is bitwise.
- R4: The chip of pair-parity user l (0 ≤ l < N/2) is `pd_bits[l]` at chip index c = 2l and 0 at every other chip index.
- R5: The count of ones among all `1.5N` chips of chip index c appears on `sum_o` two cycles after `chip_idx_o` showed c, with `sum_vld_o`=1. `sum_first_o`=1 only with the sum of chip 0. Between frames `sum_vld_o`=0.
- R6: `valid_o` rises in the same cycle as the sum of chip `N-1` and stays high while `ack_i` is low. The cycle after an edge with `valid_o` and `ack_i` both high shows `idle_o`=1 and `valid_o`=0.
- R7: A `start_i` pulse while `idle_o`=0 has no effect. This holds even in the same cycle as the acknowledge. Such a pulse captures no data, does not alter the chip sequence or the sums, and does not begin a new frame.
- R8: `sum_o` is `clog2(1.5N+1)` bits wide and carries the largest possible count without wrapping. For N=8 that count is 9, at chip 0 when every bit is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame; acted on only when idle |
| ack_i | input | 1 | Consumer has taken the frame |
| orth_bits_i | input | N | Data bits of the code-sharing users |
| pd_bits_i | input | N/2 | Data bits of the pair-parity users |
| idle_o | output | 1 | Core is ready for a start |
| valid_o | output | 1 | Frame fully on the bus, awaiting acknowledge |
| chip_idx_o | output | clog2(N) | Shared chip counter |
| sum_o | output | clog2(1.5N+1) | Registered chip sum broadcast to receivers |
| sum_vld_o | output | 1 | `sum_o` holds a chip of the current frame |
| sum_first_o | output | 1 | `sum_o` holds chip 0 of a frame |

## Verification
A wrong user code or a wrong chip counter produces a wrong count on `sum_o` two cycles after the chip index concerned, so every chip sum of every frame is compared. A controller that leaves a state early or late shifts `valid_o` or `idle_o` against the last sum or the acknowledge, and the bench sees this within one cycle. A start accepted while busy would either recapture the data, which corrupts the following sums within three cycles, or restart the counter, which `chip_idx_o` shows at once.

// File: rtl/oci_bus_pkg.sv
package oci_bus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_HOLD  = 2'd3
    } bus_state_e;

    // Walsh chip: parity of the bitwise AND of user index and chip index
    function automatic logic walsh_bit(input logic [15:0] user, input logic [15:0] chip);
        return ^(user & chip);
    endfunction

endpackage

// File: rtl/oci_bus_ctrl.sv
module oci_bus_ctrl
    import oci_bus_pkg::*;
#(
    parameter int N_ORTH = 8,
    parameter int N_PD   = N_ORTH / 2,
    parameter int CW     = $clog2(N_ORTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ack_i,
    input  logic [N_ORTH-1:0] orth_bits_i,
    input  logic [N_PD-1:0]   pd_bits_i,
    output logic              run_o,
    output logic [CW-1:0]     cnt_o,
    output logic [N_ORTH-1:0] orth_q_o,
    output logic [N_PD-1:0]   pd_q_o,
    output logic              idle_o,
    output logic              valid_o
);

    localparam logic [CW-1:0] LAST_CHIP = CW'(N_ORTH - 1);

    typedef struct packed {
        bus_state_e        state;
        logic [CW-1:0]     cnt;
        logic [N_ORTH-1:0] orth;
        logic [N_PD-1:0]   pd;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctrl_d.state = ST_RUN;
                    ctrl_d.cnt   = '0;
                    ctrl_d.orth  = orth_bits_i;
                    ctrl_d.pd    = pd_bits_i;
                end
            end
            ST_RUN: begin
                if (ctrl_q.cnt == LAST_CHIP) begin
                    ctrl_d.state = ST_DRAIN;
                    ctrl_d.cnt   = '0;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            ST_DRAIN: ctrl_d.state = ST_HOLD;
            ST_HOLD: begin
                if (ack_i) ctrl_d.state = ST_IDLE;
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_IDLE, cnt: '0, orth: '0, pd: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign run_o    = (ctrl_q.state == ST_RUN);
    assign cnt_o    = ctrl_q.cnt;
    assign orth_q_o = ctrl_q.orth;
    assign pd_q_o   = ctrl_q.pd;
    assign idle_o   = (ctrl_q.state == ST_IDLE);
    assign valid_o  = (ctrl_q.state == ST_HOLD);

    AST_BUSY_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_o |=> ($stable(orth_q_o) && $stable(pd_q_o))); // R7

    AST_CNT_ZERO_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !run_o |-> (cnt_o == '0)); // R2

    AST_IDLE_VALID_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(idle_o && valid_o)); // R6

    AST_ACK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ack_i) |=> (idle_o && !valid_o)); // R6

    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ack_i) |=> valid_o); // R6

endmodule

// File: rtl/oci_chip_encoder.sv
module oci_chip_encoder
    import oci_bus_pkg::*;
#(
    parameter int N_ORTH = 8,
    parameter int N_PD   = N_ORTH / 2,
    parameter int CW     = $clog2(N_ORTH),
    parameter int NUSR   = N_ORTH + N_PD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [CW-1:0]     cnt_i,
    input  logic [N_ORTH-1:0] orth_i,
    input  logic [N_PD-1:0]   pd_i,
    output logic [NUSR-1:0]   chips_o,
    output logic              vld_o,
    output logic              first_o
);

    typedef struct packed {
        logic [NUSR-1:0] chips;
        logic            vld;
        logic            first;
    } enc_t;

    enc_t enc_d, enc_q;
    logic [NUSR-1:0] chip_now;

    // code-sharing users: data XOR Walsh chip
    for (genvar k = 0; k < N_ORTH; k++) begin : g_orth
        assign chip_now[k] = orth_i[k] ^ walsh_bit(16'(k), 16'(cnt_i));
    end

    // pair-parity users: data gated by a single pulse at the pair's first chip
    for (genvar l = 0; l < N_PD; l++) begin : g_pd
        localparam logic [CW-1:0] PULSE_AT = CW'(2 * l);
        assign chip_now[N_ORTH + l] = pd_i[l] & (cnt_i == PULSE_AT);
    end

    always_comb begin
        enc_d       = enc_q;
        enc_d.vld   = run_i;
        enc_d.first = run_i && (cnt_i == '0);
        enc_d.chips = run_i ? chip_now : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enc_q <= '{chips: '0, vld: 1'b0, first: 1'b0};
        end else begin
            enc_q <= enc_d;
        end
    end

    assign chips_o = enc_q.chips;
    assign vld_o   = enc_q.vld;
    assign first_o = enc_q.first;

    AST_PD_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chips_o[NUSR-1:N_ORTH])); // R4

    AST_IDLE_CHIPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> (chips_o == '0)); // R5

endmodule

// File: rtl/oci_chip_adder.sv
module oci_chip_adder #(
    parameter int NUSR = 12,
    parameter int SW   = $clog2(NUSR + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NUSR-1:0] chips_i,
    input  logic            vld_i,
    input  logic            first_i,
    output logic [SW-1:0]   sum_o,
    output logic            vld_o,
    output logic            first_o
);

    typedef struct packed {
        logic [SW-1:0] sum;
        logic          vld;
        logic          first;
    } add_t;

    add_t add_d, add_q;

    always_comb begin
        logic [SW-1:0] acc;
        acc = '0;
        for (int i = 0; i < NUSR; i++) begin
            acc = acc + SW'(chips_i[i]);
        end
        add_d.sum   = acc;
        add_d.vld   = vld_i;
        add_d.first = first_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            add_q <= '{sum: '0, vld: 1'b0, first: 1'b0};
        end else begin
            add_q <= add_d;
        end
    end

    assign sum_o   = add_q.sum;
    assign vld_o   = add_q.vld;
    assign first_o = add_q.first;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sum_o) <= NUSR); // R8

    AST_SUM_MATCHES_CHIPS: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> (int'(sum_o) == $countones($past(chips_i)))); // R5

    AST_FIRST_INSIDE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        first_o |-> vld_o); // R5

endmodule

// File: rtl/oci_bus_core.sv
module oci_bus_core #(
    parameter int N_ORTH = 8,
    parameter int N_PD   = N_ORTH / 2,
    parameter int CW     = $clog2(N_ORTH),
    parameter int NUSR   = N_ORTH + N_PD,
    parameter int SW     = $clog2(NUSR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ack_i,
    input  logic [N_ORTH-1:0] orth_bits_i,
    input  logic [N_PD-1:0]   pd_bits_i,
    output logic              idle_o,
    output logic              valid_o,
    output logic [CW-1:0]     chip_idx_o,
    output logic [SW-1:0]     sum_o,
    output logic              sum_vld_o,
    output logic              sum_first_o
);

    logic              run;
    logic [CW-1:0]     cnt;
    logic [N_ORTH-1:0] orth_q;
    logic [N_PD-1:0]   pd_q;
    logic [NUSR-1:0]   enc_chips;
    logic              enc_vld;
    logic              enc_first;

    oci_bus_ctrl #(.N_ORTH(N_ORTH), .N_PD(N_PD), .CW(CW)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .ack_i      (ack_i),
        .orth_bits_i(orth_bits_i),
        .pd_bits_i  (pd_bits_i),
        .run_o      (run),
        .cnt_o      (cnt),
        .orth_q_o   (orth_q),
        .pd_q_o     (pd_q),
        .idle_o     (idle_o),
        .valid_o    (valid_o)
    );

    oci_chip_encoder #(.N_ORTH(N_ORTH), .N_PD(N_PD), .CW(CW), .NUSR(NUSR)) i_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .cnt_i  (cnt),
        .orth_i (orth_q),
        .pd_i   (pd_q),
        .chips_o(enc_chips),
        .vld_o  (enc_vld),
        .first_o(enc_first)
    );

    oci_chip_adder #(.NUSR(NUSR), .SW(SW)) i_add (
        .clk    (clk),
        .rst_n  (rst_n),
        .chips_i(enc_chips),
        .vld_i  (enc_vld),
        .first_i(enc_first),
        .sum_o  (sum_o),
        .vld_o  (sum_vld_o),
        .first_o(sum_first_o)
    );

    assign chip_idx_o = cnt;

    AST_START_OPENS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && start_i) |=> (!idle_o && chip_idx_o == '0)); // R2

    AST_VALID_WITH_LAST_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> sum_vld_o); // R6

endmodule

// File: tb/test_oci_bus_core.sv
module test_oci_bus_core;

    localparam int N  = 8;
    localparam int NP = 4;
    localparam int CW = 3;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          ack_i = 1'b0;
    logic [N-1:0]  orth_bits_i = '0;
    logic [NP-1:0] pd_bits_i = '0;
    logic          idle_o, valid_o, sum_vld_o, sum_first_o;
    logic [CW-1:0] chip_idx_o;
    logic [SW-1:0] sum_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    oci_bus_core i_oci_bus_core (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_i(ack_i),
        .orth_bits_i(orth_bits_i), .pd_bits_i(pd_bits_i),
        .idle_o(idle_o), .valid_o(valid_o), .chip_idx_o(chip_idx_o),
        .sum_o(sum_o), .sum_vld_o(sum_vld_o), .sum_first_o(sum_first_o)
    );

    // vector table: [11:8] pair-parity bits, [7:0] code-sharing bits
    localparam logic [11:0] VEC [6] = '{
        12'h000,   // R3 R4 all zero data
        12'h0FF,   // R3 code-sharing users only
        12'hF00,   // R4 pair-parity users only
        12'hFFF,   // R8 largest count at chip 0
        12'h5A3,   // mixed
        12'h96C    // mixed
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_sum(input logic [N-1:0] o, input logic [NP-1:0] p, input int c);
        int s = 0;
        for (int k = 0; k < N; k++) s += int'(o[k]) ^ ($countones(k & c) % 2);
        for (int l = 0; l < NP; l++) if (p[l] && c == 2 * l) s++;
        return s;
    endfunction

    task automatic run_frame(input logic [N-1:0] o, input logic [NP-1:0] p,
                             input bit spurious, input int hold, input string tag);
        @(negedge clk);
        orth_bits_i = o; pd_bits_i = p; start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        chk("R2", "idle after start", int'(idle_o), 0);
        chk("R2", "first chip index", int'(chip_idx_o), 0);
        for (int cyc = 1; cyc <= N + 1; cyc++) begin
            if (spurious && cyc == 3) begin
                start_i = 1'b1; orth_bits_i = ~o; pd_bits_i = ~p;  // R7
            end
            @(posedge clk); @(negedge clk);
            start_i = 1'b0;
            if (cyc < N) chk("R2", "chip index", int'(chip_idx_o), cyc);
            if (cyc >= 2) begin
                chk(tag, "chip sum", int'(sum_o), exp_sum(o, p, cyc - 2));
                chk("R5", "sum valid", int'(sum_vld_o), 1);
                chk("R5", "sum first", int'(sum_first_o), (cyc == 2) ? 1 : 0);
            end
            if (cyc == N)     chk("R6", "valid before last sum", int'(valid_o), 0);
            if (cyc == N + 1) chk("R6", "valid with last sum", int'(valid_o), 1);
        end
        for (int h = 0; h < hold; h++) begin
            @(posedge clk); @(negedge clk);
            chk("R6", "valid held", int'(valid_o), 1);
            chk("R5", "no sum between frames", int'(sum_vld_o), 0);
        end
        ack_i = 1'b1;
        @(posedge clk); @(negedge clk);
        ack_i = 1'b0;
        chk("R6", "idle after ack", int'(idle_o), 1);
        chk("R6", "valid after ack", int'(valid_o), 0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "idle", int'(idle_o), 1);
        chk("R1", "valid", int'(valid_o), 0);
        chk("R1", "sum valid", int'(sum_vld_o), 0);
        chk("R1", "sum", int'(sum_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "idle without start", int'(idle_o), 1);
        chk("R1", "sum first", int'(sum_first_o), 0);

        foreach (VEC[i]) begin
            string tg;
            tg = (i == 1) ? "R3" : (i == 2) ? "R4" : (i == 3) ? "R8" : "R5";
            run_frame(VEC[i][7:0], VEC[i][11:8], 1'b0, i % 3, tg);
        end

        // R7 start while a frame runs: sums must follow the first data
        run_frame(8'h3C, 4'h5, 1'b1, 1, "R7");

        // R7 start in hold, and start together with ack
        @(negedge clk);
        orth_bits_i = 8'h01; pd_bits_i = 4'h0; start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        repeat (N + 1) @(posedge clk);
        @(negedge clk);
        start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R7", "start in hold keeps valid", int'(valid_o), 1);
        chk("R7", "start in hold keeps busy", int'(idle_o), 0);
        ack_i = 1'b1;
        @(posedge clk); @(negedge clk);
        ack_i = 1'b0; start_i = 1'b0;
        chk("R7", "start with ack leaves idle", int'(idle_o), 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7", "no frame from start with ack", int'(sum_vld_o), 0);
        chk("R7", "still idle", int'(idle_o), 1);

        // R1 reset in mid frame
        @(negedge clk);
        orth_bits_i = 8'hFF; pd_bits_i = 4'hF; start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1", "idle after mid reset", int'(idle_o), 1);
        chk("R1", "sum after mid reset", int'(sum_o), 0);
        chk("R1", "sum valid after mid reset", int'(sum_vld_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // frame after reset still correct
        run_frame(8'hA5, 4'hA, 1'b0, 0, "R5");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule